// File: doc/BRIEF.md
# 4B/5B Transmit Symbol Encoder

This block sits on the transmit side of a 100 Mb/s physical coding layer. Every 25 MHz cycle it takes one nibble from the media-independent transmit interface and turns it into one 5-bit code group. It also frames each packet on the line. When transmit enable first comes up, the two preamble nibbles that arrive with it are overwritten by the start-of-stream pair. After enable drops, the first two idle slots carry the end-of-stream pair, and from then on the line is filled with the idle group.

A transmit-error input replaces the code group of a data nibble with the HALT group. It never changes a delimiter. A bypass control turns the encoder off so that a raw 5-bit group passes straight through: the low four bits come from the data nibble and bit 4 comes from the transmit-error input. Each code group is registered once, so it appears one clock after its inputs are sampled. A debug flag goes high for every delimiter group. Scrambling, serialisation and line coding come after this block and are not part of it.

Top module: `tx_symbol_encoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `codeOut` is 11111 (idle) and `delimFlag` is 0.
- R2: While transmit enable stays low and bypass is off, every cycle sends 11111 with `delimFlag` 0, whatever the error input does.
- R3: On the first cycle enable is sampled high from idle, the encoder sends J (11000). On the next cycle it sends K (10001). Both nibbles are discarded, `delimFlag` is 1, and each group appears one clock after its inputs are sampled.
- R4: After J/K, each nibble sampled with enable high is sent as its data group: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101. `delimFlag` is 0.
- R5: On the first cycle enable is sampled low after data, the encoder sends T (01101). It sends R (00111) on the next cycle and idle after that. `delimFlag` is 1 for T and R.
- R6: A data nibble sampled with the error input high is sent as HALT (00100), and `delimFlag` is 0.
- R7: The error input has no effect on J, K, T or R.
- R8: If enable drops during the J/K pair, the pair is still completed and is followed directly by T then R.
- R9: With bypass high, `codeOut` one clock later equals {error input, data nibble} and `delimFlag` is 0. On leaving bypass the encoder starts in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz symbol clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txData | input | 4 | Transmit nibble |
| txEnable | input | 1 | Transmit enable |
| txError | input | 1 | Transmit error; bit 4 of the raw group in bypass |
| bypassEn | input | 1 | Pass raw 5-bit groups without encoding |
| codeOut | output | 5 | Registered 5-bit code group |
| delimFlag | output | 1 | High while codeOut carries J, K, T or R |

## Verification
The hardest case to reach is an enable pulse only one or two cycles long, because then the end-of-stream pair follows the start pair with no data between them. The stimulus raises enable for a single cycle, then for exactly two cycles, and each time checks that J, K, T, R come out back to back. Error-input pulses are placed on the preamble nibbles and on the first idle slot after a frame. This shows that only data slots turn into HALT.

// File: rtl/enc45_pkg.sv
package enc45_pkg;

  localparam int NIBBLE_W = 4;
  localparam int CODE_W   = NIBBLE_W + 1;

  localparam logic [CODE_W-1:0] CODE_IDLE = 5'b11111;
  localparam logic [CODE_W-1:0] CODE_J    = 5'b11000;
  localparam logic [CODE_W-1:0] CODE_K    = 5'b10001;
  localparam logic [CODE_W-1:0] CODE_T    = 5'b01101;
  localparam logic [CODE_W-1:0] CODE_R    = 5'b00111;
  localparam logic [CODE_W-1:0] CODE_HALT = 5'b00100;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SENDK = 2'd1,
    ST_DATA  = 2'd2,
    ST_SENDR = 2'd3
  } encStateT;

  // strobes from control to datapath; none set means idle fill
  typedef struct packed {
    logic selJ;
    logic selK;
    logic selT;
    logic selR;
    logic selData;
    logic selHalt;
    logic selBypass;
  } encStrobeT;

  function automatic logic [CODE_W-1:0] dataCode(input logic [NIBBLE_W-1:0] nib);
    logic [CODE_W-1:0] c;
    case (nib)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tx_enc_ctrl.sv
module tx_enc_ctrl
  import enc45_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnable,
  input  logic      txError,
  input  logic      bypassEn,
  output encStrobeT strobes
);

  encStateT state, nextState;

  always_comb begin
    strobes   = '0;
    nextState = state;
    if (bypassEn) begin
      strobes.selBypass = 1'b1;
      nextState         = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (txEnable) begin
            strobes.selJ = 1'b1;
            nextState    = ST_SENDK;
          end
        end
        ST_SENDK: begin
          strobes.selK = 1'b1;
          nextState    = ST_DATA;
        end
        ST_DATA: begin
          if (txEnable) begin
            if (txError) strobes.selHalt = 1'b1;
            else         strobes.selData = 1'b1;
          end else begin
            strobes.selT = 1'b1;
            nextState    = ST_SENDR;
          end
        end
        default: begin
          strobes.selR = 1'b1;
          nextState    = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R7
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R3
  jk_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selJ |=> (strobes.selK || strobes.selBypass));

  // R5
  tr_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selT |=> (strobes.selR || strobes.selBypass));

  // R8
  k_then_data_or_t_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selK |=> (strobes.selData || strobes.selHalt || strobes.selT || strobes.selBypass));

endmodule

// File: rtl/tx_enc_datapath.sv
module tx_enc_datapath
  import enc45_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NIBBLE_W-1:0] txData,
  input  logic                txError,
  input  encStrobeT           strobes,
  output logic [CODE_W-1:0]   codeOut,
  output logic                delimFlag
);

  logic [CODE_W-1:0] codeNext;
  logic              delimNext;

  always_comb begin
    codeNext = CODE_IDLE;
    if      (strobes.selBypass) codeNext = {txError, txData};
    else if (strobes.selJ)      codeNext = CODE_J;
    else if (strobes.selK)      codeNext = CODE_K;
    else if (strobes.selT)      codeNext = CODE_T;
    else if (strobes.selR)      codeNext = CODE_R;
    else if (strobes.selHalt)   codeNext = CODE_HALT;
    else if (strobes.selData)   codeNext = dataCode(txData);
    delimNext = strobes.selJ | strobes.selK | strobes.selT | strobes.selR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeOut   <= CODE_IDLE;
      delimFlag <= 1'b0;
    end else begin
      codeOut   <= codeNext;
      delimFlag <= delimNext;
    end
  end

  // R6
  halt_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selHalt |=> (codeOut == CODE_HALT && !delimFlag));

  // R9
  bypass_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selBypass |=> !delimFlag);

  // R4
  data_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selData |=> !delimFlag);

endmodule

// File: rtl/tx_symbol_encoder.sv
module tx_symbol_encoder
  import enc45_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NIBBLE_W-1:0] txData,
  input  logic                txEnable,
  input  logic                txError,
  input  logic                bypassEn,
  output logic [CODE_W-1:0]   codeOut,
  output logic                delimFlag
);

  encStrobeT strobes;

  tx_enc_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .txEnable (txEnable),
    .txError  (txError),
    .bypassEn (bypassEn),
    .strobes  (strobes)
  );

  tx_enc_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .txData    (txData),
    .txError   (txError),
    .strobes   (strobes),
    .codeOut   (codeOut),
    .delimFlag (delimFlag)
  );

endmodule

// File: tb/tx_symbol_encoder_tb_top.sv
module tx_symbol_encoder_tb_top;

  localparam int CLK_NS = 8;

  typedef struct {
    logic [4:0] code;
    logic       flag;
    string      tag;
  } expT;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] txData = 4'h0;
  logic       txEnable = 1'b0;
  logic       txError = 1'b0;
  logic       bypassEn = 1'b0;
  logic [4:0] codeOut;
  logic       delimFlag;

  int checks = 0;
  int errors = 0;
  int mState = 0;
  string note = "";
  expT scoreQ[$];
  logic [4:0] tbl [16];

  always #(CLK_NS/2) clk = ~clk;

  tx_symbol_encoder dut_i (
    .clk(clk), .rstN(rstN), .txData(txData), .txEnable(txEnable),
    .txError(txError), .bypassEn(bypassEn), .codeOut(codeOut), .delimFlag(delimFlag)
  );

  // driver: drive at negedge, push the expected group for the next edge
  task automatic drive(input logic en, input logic er, input logic [3:0] d, input logic byp);
    expT e;
    txEnable = en; txError = er; txData = d; bypassEn = byp;
    if (byp) begin
      e.code = {er, d}; e.flag = 1'b0; e.tag = "R9"; mState = 0;
    end else begin
      case (mState)
        0: if (en) begin e.code = 5'b11000; e.flag = 1'b1; e.tag = er ? "R7" : "R3"; mState = 1; end
           else    begin e.code = 5'b11111; e.flag = 1'b0; e.tag = "R2"; end
        1: begin e.code = 5'b10001; e.flag = 1'b1; e.tag = er ? "R7" : "R3"; mState = 2; end
        2: if (en) begin
             e.code = er ? 5'b00100 : tbl[d]; e.flag = 1'b0; e.tag = er ? "R6" : "R4";
           end else begin
             e.code = 5'b01101; e.flag = 1'b1; e.tag = er ? "R7" : "R5"; mState = 3;
           end
        default: begin e.code = 5'b00111; e.flag = 1'b1; e.tag = er ? "R7" : "R5"; mState = 0; end
      endcase
    end
    if (note != "") e.tag = note;
    scoreQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got flag/code %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: sample after each rising edge
  always @(posedge clk) begin
    #2;
    if (rstN && scoreQ.size() > 0) begin
      expT e;
      e = scoreQ.pop_front();
      check(e.tag, {delimFlag, codeOut}, {e.flag, e.code});
    end
  end

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tbl = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
            5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};
    // R1 reset state
    #(CLK_NS * 3 + 2);
    check("R1", {delimFlag, codeOut}, 6'b011111);
    @(negedge clk);
    rstN = 1'b1;
    // R1 first cycle after reset is idle
    note = "R1"; drive(0, 0, 4'h0, 0); note = "";
    // R2 idle fill, error ignored while enable low
    drive(0, 1, 4'h3, 0);
    drive(0, 0, 4'hA, 0);
    drive(0, 1, 4'hF, 0);
    // R3/R4/R5 full frame: preamble then every nibble value
    drive(1, 0, 4'h5, 0);
    drive(1, 0, 4'h5, 0);
    for (int i = 0; i < 16; i++) drive(1, 0, i[3:0], 0);
    drive(0, 0, 4'h0, 0);
    drive(0, 0, 4'h0, 0);
    drive(0, 0, 4'h0, 0);
    drive(0, 0, 4'h0, 0);
    // R6/R7 error on preamble, on data and on the end slots
    drive(1, 1, 4'h5, 0);
    drive(1, 1, 4'h5, 0);
    drive(1, 0, 4'h9, 0);
    drive(1, 1, 4'hC, 0);
    drive(1, 1, 4'h0, 0);
    drive(1, 0, 4'hE, 0);
    drive(0, 1, 4'h0, 0);
    drive(0, 1, 4'h0, 0);
    drive(0, 0, 4'h0, 0);
    // R8 enable for one cycle, then for two cycles
    note = "R8";
    drive(1, 0, 4'h5, 0);
    drive(0, 0, 4'h0, 0);
    drive(0, 0, 4'h0, 0);
    drive(0, 0, 4'h0, 0);
    drive(0, 0, 4'h0, 0);
    drive(1, 0, 4'h5, 0);
    drive(1, 0, 4'h5, 0);
    drive(0, 0, 4'h0, 0);
    drive(0, 0, 4'h0, 0);
    drive(0, 0, 4'h0, 0);
    note = "";
    // R9 bypass, including entry mid-frame and leaving to idle
    drive(1, 0, 4'h5, 0);
    drive(1, 0, 4'h5, 0);
    drive(1, 0, 4'h7, 1);
    drive(0, 1, 4'h2, 1);
    drive(1, 1, 4'hF, 1);
    drive(0, 0, 4'h0, 1);
    drive(0, 1, 4'h1, 1);
    note = "R9"; drive(0, 0, 4'h6, 0); note = "";
    // back-to-back frames
    drive(1, 0, 4'h5, 0);
    drive(1, 0, 4'h5, 0);
    drive(1, 0, 4'hB, 0);
    drive(0, 0, 4'h0, 0);
    drive(1, 0, 4'h5, 0);
    drive(1, 0, 4'h5, 0);
    drive(1, 0, 4'h5, 0);
    drive(1, 0, 4'hD, 0);
    drive(0, 0, 4'h0, 0);
    drive(0, 0, 4'h0, 0);
    drive(0, 0, 4'h0, 0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule